// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the serial front end of a 16K x 8 non-volatile memory. It accepts SPI mode 0 or mode 3 traffic from a host, decodes a one-byte instruction, gathers a 16-bit address where one is needed, and then either streams array bytes back to the host or passes incoming data bytes to an external page buffer. The storage array, the status register contents, write protection and the self-timed programming engine live outside. The engine reaches them through single-cycle request and pulse ports on a fast system clock.

SCK, chip select, SI and the pause input are brought into the system clock domain by two-flop synchronisers. Edges are found by comparing each synchronised level with its previous value, so SCK must stay high and low for at least six system clocks. A read request is answered on `rd_data` during the cycle after `rd_req`. The serial output is modelled as a data bit `spi_so` plus an enable `spi_so_en`. The pad drives only while the enable is high and floats otherwise.

The sequencer has these states. IDLE (deselected standby). OPCODE (collect 8 instruction bits). ADDR (collect 16 address bits). READ (stream array bytes). WRITE (collect data bytes). STAT_RD (stream status). STAT_WR (collect one status byte). STAT_ARM, ON_ARM and OFF_ARM (a complete command waiting for chip select to rise). DISCARD (ignore everything until deselect).

Its transitions are as follows. IDLE goes to OPCODE on a chip-select falling edge. OPCODE goes to ADDR for read or write, to STAT_RD, to STAT_WR, to ON_ARM or OFF_ARM, or to DISCARD for any other code. ADDR goes to READ, to WRITE, or to DISCARD for a read while the array is busy. STAT_WR goes to STAT_ARM after 8 bits. Any ARM state goes to DISCARD on a further bit. Every state returns to IDLE on deselect.

Top module: `spi_mem_slave`

## Requirements
- R1: Six instruction codes are decoded, and every field arrives MSB first: 0x03 read array, 0x02 write array, 0x06 set write-enable, 0x04 clear write-enable, 0x05 read status, 0x01 write status.
- R2: SI is sampled on rising SCK edges only, and SO changes only after falling SCK edges, in both SPI mode 0 and mode 3. During instruction and address bits `spi_so_en` stays low.
- R3: After a read or write instruction, 16 address bits follow. The top two are ignored, so the pointer is 14 bits wide.
- R4: Each byte streamed by a read advances the pointer by one, and 0x3FFF is followed by 0x0000. `rd_addr` carries the pointer whenever `rd_req` pulses.
- R5: Chip select high ends any operation and drops `spi_so_en` low. After reset, no command is taken until chip select has a falling edge.
- R6: If the pause input is low while SCK is low, SCK and SI edges are ignored and `spi_so_en` is low. Once it returns high while SCK is low, the transfer resumes at the bit where it stopped.
- R7: If the pause input falls while SCK is high, the next falling SCK edge is still acted on, and the pause starts after it.
- R8: If `wr_busy` is high when a read address completes, no `rd_req` is issued and `spi_so_en` stays low until chip select rises.
- R9: During a write, each complete data byte gives one `wr_byte_valid` pulse with its data and its address, starting at the sent address and incrementing. `wr_commit` pulses when chip select rises at a byte boundary after at least one byte, and not otherwise.
- R10: A set-enable or clear-enable instruction pulses `wr_en_set` or `wr_en_clr` when chip select rises after exactly 8 bits. Any further bit cancels it.
- R11: A status read returns `status_in` as every byte while clocks continue. A status write pulses `sr_wr_valid` with the data byte when chip select rises after exactly 16 bits.
- R12: An unknown instruction code is ignored. The output stays disabled and no pulse is produced until chip select rises.
- R13: After reset, `spi_so_en` and all request and pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_so | output | 1 | Serial data out bit |
| spi_so_en | output | 1 | Output enable for the SO pad |
| rd_req | output | 1 | Array read request pulse |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array read data, valid the cycle after `rd_req` |
| wr_busy | input | 1 | Internal programming cycle in progress |
| wr_byte_valid | output | 1 | Data byte for the page buffer |
| wr_byte_addr | output | ADDR_W | Address of that byte |
| wr_byte_data | output | 8 | The byte |
| wr_commit | output | 1 | Start programming of the buffered page |
| status_in | input | 8 | Status byte to return |
| sr_wr_valid | output | 1 | Status write pulse |
| sr_wr_data | output | 8 | Status byte to write |
| wr_en_set | output | 1 | Set write-enable pulse |
| wr_en_clr | output | 1 | Clear write-enable pulse |

## Verification
The bench targets the pointer wrap from 0x3FFF to zero when the top address bits are set. A design that kept 16 bits, or failed to wrap, would return data from the wrong address. Pauses are placed with SCK low and with SCK high, in both address and data bytes, with junk clocks toggled during the pause. If junk edges were counted, the address or the data would shift by a bit; if the post-fall edge were handled wrongly, one bit would be lost. The bench also checks several framing cases: chip select held low through reset, writes aborted in mid-byte, enable commands followed by extra bits, and reads issued while the array is busy. Each of these must produce no pulse and no driven output. A design that committed on any deselect, or that returned array data while programming, would fail these checks.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    localparam int BYTE_W       = 8;
    localparam int ADDR_FIELD_W = 16;
    localparam int CNT_W        = $clog2(ADDR_FIELD_W);

    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [7:0] OP_WRITE     = 8'h02;
    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_LATCH_OFF = 8'h04;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_LATCH_ON  = 8'h06;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_READ,
        ST_WRITE,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_STAT_ARM,
        ST_ON_ARM,
        ST_OFF_ARM,
        ST_DISCARD
    } slv_state_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[g] <= RST_VAL[g];
                q[g]    <= RST_VAL[g];
            end else begin
                meta[g] <= d[g];
                q[g]    <= meta[g];
            end
        end
    end
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic hold_s,
    output logic held,
    output logic sck_rise,
    output logic sck_fall
);
    logic sck_q;

    // The pause state only changes while SCK is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            held  <= 1'b0;
        end else begin
            sck_q <= sck_s;
            if (!sck_s) held <= !hold_s;
        end
    end

    assign sck_rise = sck_s & !sck_q & !held;
    assign sck_fall = !sck_s & sck_q & !held;

    AST_HOLD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !sck_s) |=> held); // R6
    AST_HOLD_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_s && $past(sck_s)) |-> $stable(held)); // R7
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    input  logic              spi_hold_n,
    output logic              spi_so,
    output logic              spi_so_en,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic              wr_busy,
    output logic              wr_byte_valid,
    output logic [ADDR_W-1:0] wr_byte_addr,
    output logic [7:0]        wr_byte_data,
    output logic              wr_commit,
    input  logic [7:0]        status_in,
    output logic              sr_wr_valid,
    output logic [7:0]        sr_wr_data,
    output logic              wr_en_set,
    output logic              wr_en_clr
);
    localparam int          ISR_W    = ADDR_W - 1;
    localparam logic [CNT_W-1:0] LAST_OP   = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_FIELD_W - 1);

    logic sck_s, cs_s, si_s, hold_s;
    logic cs_q, cs_fall, cs_rise;
    logic held, rise_g, fall_g;

    spi_in_sync #(.W(4), .RST_VAL(4'b1000)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_hold_n, spi_cs_n, spi_si, spi_sck}),
        .q    ({hold_s, cs_s, si_s, sck_s})
    );

    spi_hold_gate i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sck_s),
        .hold_s  (hold_s),
        .held    (held),
        .sck_rise(rise_g),
        .sck_fall(fall_g)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs_s;
    end
    assign cs_fall = !cs_s & cs_q;
    assign cs_rise = cs_s & !cs_q;

    slv_state_e       state, nxt_state;
    logic [CNT_W-1:0] cnt;
    logic [ISR_W-1:0] isr;
    logic [ADDR_W-1:0] ptr;
    logic             op_rd, has_byte, drv, rd_pend;
    logic [7:0]       obuf, pre, src;
    logic             so_q;
    logic [7:0]       byte_in;
    logic [ADDR_W-1:0] word_in;

    assign byte_in = {isr[6:0], si_s};
    assign word_in = {isr, si_s};
    assign src     = (state == ST_READ) ? pre : status_in;

    // Next-state logic
    always_comb begin
        nxt_state = state;
        if (cs_s) begin
            nxt_state = ST_IDLE;
        end else if (cs_fall) begin
            nxt_state = ST_OPCODE;
        end else begin
            unique case (state)
                ST_IDLE: nxt_state = ST_IDLE;
                ST_OPCODE: begin
                    if (rise_g && cnt == LAST_OP) begin
                        case (byte_in)
                            OP_READ, OP_WRITE: nxt_state = ST_ADDR;
                            OP_STAT_RD:        nxt_state = ST_STAT_RD;
                            OP_STAT_WR:        nxt_state = ST_STAT_WR;
                            OP_LATCH_ON:       nxt_state = ST_ON_ARM;
                            OP_LATCH_OFF:      nxt_state = ST_OFF_ARM;
                            default:           nxt_state = ST_DISCARD;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (rise_g && cnt == LAST_ADDR)
                        nxt_state = !op_rd ? ST_WRITE :
                                    (wr_busy ? ST_DISCARD : ST_READ);
                end
                ST_STAT_WR: begin
                    if (rise_g && cnt == LAST_OP) nxt_state = ST_STAT_ARM;
                end
                ST_STAT_ARM, ST_ON_ARM, ST_OFF_ARM: begin
                    if (rise_g) nxt_state = ST_DISCARD;
                end
                ST_READ, ST_WRITE, ST_STAT_RD, ST_DISCARD: nxt_state = state;
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; isr <= '0; ptr <= '0; op_rd <= 1'b0;
            has_byte <= 1'b0; drv <= 1'b0; so_q <= 1'b0; obuf <= '0;
            rd_req <= 1'b0; rd_pend <= 1'b0; pre <= '0;
            wr_byte_valid <= 1'b0; wr_byte_addr <= '0; wr_byte_data <= '0;
            wr_commit <= 1'b0; sr_wr_valid <= 1'b0; sr_wr_data <= '0;
            wr_en_set <= 1'b0; wr_en_clr <= 1'b0;
        end else begin
            rd_req        <= 1'b0;
            wr_byte_valid <= 1'b0;
            wr_commit     <= 1'b0;
            sr_wr_valid   <= 1'b0;
            wr_en_set     <= 1'b0;
            wr_en_clr     <= 1'b0;
            rd_pend       <= rd_req;
            if (rd_pend) pre <= rd_data;

            if (cs_s) begin
                cnt      <= '0;
                drv      <= 1'b0;
                has_byte <= 1'b0;
                if (cs_rise) begin
                    wr_en_set   <= (state == ST_ON_ARM);
                    wr_en_clr   <= (state == ST_OFF_ARM);
                    sr_wr_valid <= (state == ST_STAT_ARM);
                    wr_commit   <= (state == ST_WRITE) && (cnt[2:0] == 3'd0) && has_byte;
                end
            end else if (cs_fall) begin
                cnt      <= '0;
                drv      <= 1'b0;
                has_byte <= 1'b0;
            end else begin
                if (rise_g) begin
                    isr <= word_in[ISR_W-1:0];
                    cnt <= (nxt_state != state) ? '0 : cnt + 1'b1;
                    if (state == ST_OPCODE && cnt == LAST_OP)
                        op_rd <= (byte_in == OP_READ);
                    if (state == ST_ADDR && cnt == LAST_ADDR) begin
                        ptr <= word_in;
                        if (op_rd && !wr_busy) rd_req <= 1'b1;
                    end
                    if (state == ST_READ && cnt[2:0] == 3'd7) begin
                        ptr    <= ptr + 1'b1;
                        rd_req <= 1'b1;
                    end
                    if (state == ST_WRITE && cnt[2:0] == 3'd7) begin
                        wr_byte_valid <= 1'b1;
                        wr_byte_addr  <= ptr;
                        wr_byte_data  <= byte_in;
                        ptr           <= ptr + 1'b1;
                        has_byte      <= 1'b1;
                    end
                    if (state == ST_STAT_WR && cnt == LAST_OP)
                        sr_wr_data <= byte_in;
                end
                if (fall_g && (state == ST_READ || state == ST_STAT_RD)) begin
                    drv <= 1'b1;
                    if (cnt[2:0] == 3'd0) begin
                        obuf <= src;
                        so_q <= src[7];
                    end else begin
                        so_q <= obuf[3'd7 - cnt[2:0]];
                    end
                end
            end
        end
    end

    assign rd_addr   = ptr;
    assign spi_so    = so_q;
    assign spi_so_en = drv & !held & !cs_s & (state == ST_READ || state == ST_STAT_RD);

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |=> (!spi_so_en && state == ST_IDLE)); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(state) == ST_READ) |-> rd_addr == $past(rd_addr) + 1'b1); // R4
    AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(state) == ST_ADDR) |-> !$past(wr_busy)); // R8
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(held) && !$past(cs_s) && !$past(cs_s, 2)) |-> $stable(cnt)); // R6
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_set, wr_en_clr, sr_wr_valid, wr_commit})); // R10
    AST_COMMIT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> cs_s); // R9
endmodule

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;
    localparam int HALF = 8;
    localparam logic [7:0] C_RD = 8'h03, C_WR = 8'h02, C_ON = 8'h06,
                           C_OFF = 8'h04, C_SRD = 8'h05, C_SWR = 8'h01;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1;
    logic spi_so, spi_so_en, rd_req, wr_byte_valid, wr_commit;
    logic sr_wr_valid, wr_en_set, wr_en_clr, wr_busy = 1'b0;
    logic [13:0] rd_addr, wr_byte_addr;
    logic [7:0] rd_data, wr_byte_data, sr_wr_data, status_in = 8'hA6;

    int checks = 0, fails = 0;
    int n_set = 0, n_clr = 0, n_srw = 0, n_com = 0, n_wb = 0, n_rq = 0;
    logic [13:0] wb_addr [0:7];
    logic [7:0]  wb_data [0:7];
    logic [7:0]  srw_last = '0;
    bit en_seen = 0, m3 = 0, done = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b10};
    endfunction
    assign rd_data = mem_val(rd_addr);

    spi_mem_slave i_spi_mem_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so),
        .spi_so_en(spi_so_en), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_busy(wr_busy), .wr_byte_valid(wr_byte_valid),
        .wr_byte_addr(wr_byte_addr), .wr_byte_data(wr_byte_data),
        .wr_commit(wr_commit), .status_in(status_in), .sr_wr_valid(sr_wr_valid),
        .sr_wr_data(sr_wr_data), .wr_en_set(wr_en_set), .wr_en_clr(wr_en_clr)
    );

    always @(negedge clk) if (rst_n) begin
        if (wr_en_set) n_set++;
        if (wr_en_clr) n_clr++;
        if (sr_wr_valid) begin n_srw++; srw_last = sr_wr_data; end
        if (wr_commit) n_com++;
        if (rd_req) n_rq++;
        if (wr_byte_valid) begin
            wb_addr[n_wb % 8] = wr_byte_addr;
            wb_data[n_wb % 8] = wr_byte_data;
            n_wb++;
        end
        if (spi_so_en) en_seen = 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_begin();
        spi_sck = m3;
        half();
        spi_cs_n = 1'b0;
        half();
    endtask

    task automatic cs_end();
        half();
        spi_cs_n = 1'b1;
        half(); half();
    endtask

    // hold_at: bit index at which a pause is inserted (-1: none)
    task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                        input bit hold_hi, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            if (m3) spi_sck = 1'b0;
            spi_si = tx[7 - i];
            half();
            rx[7 - i] = spi_so & spi_so_en;
            spi_sck = 1'b1;
            if (hold_at == i && hold_hi) spi_hold_n = 1'b0;
            half();
            if (!m3) spi_sck = 1'b0;
            if (hold_at == i) begin
                half();
                spi_hold_n = 1'b0;
                half();
                check(spi_so_en == 1'b0, hold_hi ? "R7 pause output" : "R6 pause output",
                      spi_so_en, 0);
                for (int k = 0; k < 3; k++) begin
                    spi_si = ~spi_si;
                    spi_sck = 1'b1; half();
                    spi_sck = 1'b0; half();
                end
                spi_hold_n = 1'b1;
                half();
            end
        end
    endtask

    // hb: -1 no pause, -2 pause in high address byte, else data byte index
    task automatic do_read(input logic [15:0] a, input int n, input int hb,
                           input int hbit, input bit hhi, input string tag);
        logic [7:0] rx;
        logic [13:0] p;
        p = a[13:0];
        cs_begin();
        en_seen = 0;
        xfer(C_RD, 8, -1, 0, rx);
        xfer(a[15:8], 8, (hb == -2) ? hbit : -1, hhi, rx);
        xfer(a[7:0], 8, -1, 0, rx);
        check(en_seen == 0, "R2 output quiet in header", en_seen, 0);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, 8, (hb == i) ? hbit : -1, hhi, rx);
            check(rx == mem_val(p), tag, rx, mem_val(p));
            p = p + 1'b1;
        end
        cs_end();
        check(spi_so_en == 1'b0, "R5 released on deselect", spi_so_en, 0);
    endtask

    initial begin
        logic [7:0] rx;
        int b0, b1;
        void'($urandom(32'h5EED));
        spi_cs_n = 1'b0;               // selected through reset
        repeat (5) @(negedge clk);
        check(spi_so_en == 0 && rd_req == 0 && wr_byte_valid == 0 && wr_commit == 0 &&
              sr_wr_valid == 0 && wr_en_set == 0 && wr_en_clr == 0, "R13 reset outputs", 1, 0);
        rst_n = 1'b1;
        half();
        // R5: no falling edge yet, so this command is not taken
        xfer(C_ON, 8, -1, 0, rx);
        cs_end();
        check(n_set == 0, "R5 power-up needs CS fall", n_set, 0);

        cs_begin(); xfer(C_ON, 8, -1, 0, rx); cs_end();
        check(n_set == 1, "R10 set-enable", n_set, 1);
        cs_begin(); xfer(C_OFF, 8, -1, 0, rx); cs_end();
        check(n_clr == 1, "R10 clear-enable", n_clr, 1);
        cs_begin(); xfer(C_ON, 8, -1, 0, rx); xfer(8'h00, 1, -1, 0, rx); cs_end();
        check(n_set == 1, "R10 extra bit cancels", n_set, 1);

        do_read(16'h0100, 4, -1, 0, 0, "R1 read data");
        do_read(16'hFFFE, 4, -1, 0, 0, "R3 R4 wrap with top bits");
        for (int t = 0; t < 12; t++)
            do_read(16'($urandom), 1 + int'($urandom % 5), -1, 0, 0, "R4 random read");

        do_read(16'h1234, 3, 1, 3, 0, "R6 pause low in data");
        do_read(16'h2A55, 3, 0, 5, 1, "R7 pause high in data");
        do_read(16'h0F0F, 2, -2, 2, 0, "R6 pause in address");

        m3 = 1;
        do_read(16'h3FFF, 3, -1, 0, 0, "R2 mode 3 read");
        m3 = 0;
        spi_sck = 1'b0;
        half();

        b0 = n_wb; b1 = n_com;
        cs_begin();
        xfer(C_WR, 8, -1, 0, rx); xfer(8'hC1, 8, -1, 0, rx); xfer(8'h23, 8, -1, 0, rx);
        xfer(8'h5A, 8, -1, 0, rx); xfer(8'h81, 8, -1, 0, rx); xfer(8'hE7, 8, -1, 0, rx);
        cs_end();
        check(n_wb - b0 == 3, "R9 byte count", n_wb - b0, 3);
        check(wb_addr[b0 % 8] == 14'h0123 && wb_data[b0 % 8] == 8'h5A, "R9 first byte",
              {wb_addr[b0 % 8], wb_data[b0 % 8]}, {14'h0123, 8'h5A});
        check(wb_addr[(b0 + 2) % 8] == 14'h0125 && wb_data[(b0 + 2) % 8] == 8'hE7,
              "R9 last byte", {wb_addr[(b0 + 2) % 8], wb_data[(b0 + 2) % 8]}, {14'h0125, 8'hE7});
        check(n_com - b1 == 1, "R9 commit", n_com - b1, 1);

        b0 = n_wb; b1 = n_com;
        cs_begin();
        xfer(C_WR, 8, -1, 0, rx); xfer(8'h00, 8, -1, 0, rx); xfer(8'h40, 8, -1, 0, rx);
        xfer(8'h77, 8, -1, 0, rx); xfer(8'hAA, 4, -1, 0, rx);
        cs_end();
        check(n_wb - b0 == 1, "R9 partial bytes", n_wb - b0, 1);
        check(n_com == b1, "R9 mid-byte no commit", n_com - b1, 0);

        cs_begin(); xfer(C_SRD, 8, -1, 0, rx);
        xfer(8'h00, 8, -1, 0, rx); check(rx == 8'hA6, "R11 status byte 1", rx, 8'hA6);
        status_in = 8'h3C;
        xfer(8'h00, 8, -1, 0, rx); check(rx == 8'h3C, "R11 status byte 2", rx, 8'h3C);
        cs_end();
        cs_begin(); xfer(C_SWR, 8, -1, 0, rx); xfer(8'h8C, 8, -1, 0, rx); cs_end();
        check(n_srw == 1 && srw_last == 8'h8C, "R11 status write", srw_last, 8'h8C);

        b0 = n_set + n_clr + n_srw + n_com + n_wb;
        cs_begin(); en_seen = 0;
        xfer(8'hA5, 8, -1, 0, rx); xfer(8'h00, 8, -1, 0, rx); xfer(8'hFF, 8, -1, 0, rx);
        cs_end();
        check(en_seen == 0, "R12 unknown code quiet", en_seen, 0);
        check(n_set + n_clr + n_srw + n_com + n_wb == b0, "R12 no pulses",
              n_set + n_clr + n_srw + n_com + n_wb - b0, 0);

        wr_busy = 1'b1;
        b0 = n_rq;
        cs_begin(); en_seen = 0;
        xfer(C_RD, 8, -1, 0, rx); xfer(8'h01, 8, -1, 0, rx); xfer(8'h00, 8, -1, 0, rx);
        xfer(8'h00, 8, -1, 0, rx); xfer(8'h00, 8, -1, 0, rx);
        cs_end();
        check(en_seen == 0, "R8 no output while busy", en_seen, 0);
        check(n_rq == b0, "R8 no read request", n_rq - b0, 0);
        wr_busy = 1'b0;
        do_read(16'h0100, 1, -1, 0, 0, "R8 read after busy");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule